// File: doc/BRIEF.md
# Quarter-Rate Read Word Alignment and Latency Equaliser

This block runs once the read capture clock has been centred. The fabric clock runs at one quarter of the memory clock, so each fabric word of a byte group holds four memory-clock beats. Depending on where the data lands, those beats can straddle two fabric words. When a calibration is started, the block requests back-to-back reads of a known pattern word. For each byte group it then shifts the captured beat stream one beat at a time until the pattern comes out whole and in order. The shift count and the lock or fail state of each group are exported, so that a write calibration stage can use them as feedback.

After every group has locked, the block pauses the reads until the data path is empty. It then sends a single probe read and counts, for each group, the fabric cycles until the aligned pattern appears. The slowest group sets the common latency. Every faster group is delayed by whole fabric cycles so that all groups present a read's word in the same cycle.

The common latency drives a shift pipeline. That pipeline turns the controller's read-issue strobe into a read-valid strobe that lines up with the equalised data.

Top module: `qr_read_align`

## Requirements
- R1: While reset is held and after its release, cal_done, cal_err, cal_rd_en, rd_valid, grp_locked and grp_fail are all low.
- R2: From the cycle after cal_start is accepted, cal_rd_en stays high in every cycle until each group has either locked or failed.
- R3: Within a group's slice, beat 0 (the earliest in time) is in the lowest BEAT_W bits. A group whose beat stream arrives r beats late (0 to 3) ends locked with grp_slip equal to r. grp_slip holds 2 bits per group, with group g at bits [2g+1:2g]. A group locks only after MATCH_COUNT consecutive ordered matches against pattern.
- R4: If a group's data matches the pattern at none of the four shift positions, its grp_fail bit rises and cal_err is set. cal_done then rises without any probe read.
- R5: A group's shift count never exceeds 3 and never wraps. A group that fails reports a grp_slip of 3.
- R6: After all groups have locked, cal_rd_en goes low for a drain interval. It is then high for exactly one cycle (the probe) before cal_done rises.
- R7: Let L_g be the number of cycles from the read-issue cycle to the fabric cycle in which group g's first pattern beat is captured. Then common_lat equals the maximum over all groups of L_g + 2.
- R8: Group g occupies slice g of dout. After a successful calibration, for a read issued in cycle c, every group's slice equals pattern in cycle c + common_lat, and in no cycle without such a read.
- R9: rd_valid is high in cycle c + common_lat exactly when rd_issue was high in cycle c. This holds only while cal_done is high and cal_err is low; otherwise rd_valid is low.
- R10: If any group's latency differs from the slowest by more than DLY_DEPTH fabric cycles, cal_err is set, no group reports a failure, and rd_valid stays low.
- R11: A cal_start accepted while calibration is done drops cal_done and clears all locks in the next cycle, and then runs a fresh calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (quarter of memory clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Pulse to begin (or restart) calibration |
| pattern | input | 4*BEAT_W | Expected ordered word, beat 0 in the low bits |
| raw_data | input | GROUPS*4*BEAT_W | Captured words of all groups, group g at slice g |
| rd_issue | input | 1 | Read-issue strobe from the controller in normal operation |
| cal_rd_en | output | 1 | Calibration read request (continuous, then one probe) |
| grp_locked | output | GROUPS | Per-group aligned flag |
| grp_fail | output | GROUPS | Per-group alignment failure |
| grp_slip | output | 2*GROUPS | Per-group applied beat shift |
| common_lat | output | $clog2(MAX_LAT+1) | Calibrated common latency in fabric cycles |
| cal_done | output | 1 | Calibration finished |
| cal_err | output | 1 | Calibration finished with an error |
| rd_valid | output | 1 | Read-issue strobe delayed by common_lat |
| dout | output | GROUPS*4*BEAT_W | Aligned, latency-matched data |

## Verification
Two overlaps matter here. First, one group can reach lock in the same cycle in which a neighbour is still shifting. Second, a new read can be issued while earlier reads are still inside the valid pipeline and the delay lines. The bench provokes the first by giving every group its own random beat rotation and latency, and judges each group separately through its reported shift count and lock. It provokes the second by issuing random back-to-back reads after calibration. In every cycle it compares rd_valid and each group's slice against a history of the reads it issued, shifted by the latency it computed itself.

// File: rtl/qra_pkg.sv
package qra_pkg;
   localparam int BEATS = 4;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ALIGN,
      S_DRAIN,
      S_PROBE,
      S_MEASURE,
      S_EQUAL,
      S_DONE
   } cal_state_t;
endpackage

// File: rtl/qra_slip_lane.sv
module qra_slip_lane #(
   parameter int BEAT_W      = 8,
   parameter int MATCH_COUNT = 3,
   parameter int SETTLE_INIT = 19
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         align_en,
   input  logic [qra_pkg::BEATS*BEAT_W-1:0] raw,
   input  logic [qra_pkg::BEATS*BEAT_W-1:0] expect_w,
   output logic [qra_pkg::BEATS*BEAT_W-1:0] aligned,
   output logic                         locked,
   output logic                         fail,
   output logic [1:0]                   slip
);
   localparam int WORD_W = qra_pkg::BEATS * BEAT_W;
   localparam int SW     = $clog2(SETTLE_INIT + 1);
   localparam int MW     = $clog2(MATCH_COUNT + 1);

   logic [WORD_W-1:0]   prev_q;
   logic [WORD_W-1:0]   aligned_q;
   logic [2*WORD_W-1:0] win;
   logic [1:0]          slip_q;
   logic [SW-1:0]       settle_q;
   logic [MW-1:0]       match_q;
   logic                locked_q;
   logic                fail_q;

   // older word in the low half: window index 0 is the earliest beat
   assign win = {raw, prev_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= '0;
         aligned_q <= '0;
      end else begin
         prev_q    <= raw;
         aligned_q <= win[slip_q*BEAT_W +: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slip_q   <= '0;
         settle_q <= '0;
         match_q  <= '0;
         locked_q <= 1'b0;
         fail_q   <= 1'b0;
      end else if (clr) begin
         slip_q   <= '0;
         settle_q <= SW'(SETTLE_INIT);
         match_q  <= '0;
         locked_q <= 1'b0;
         fail_q   <= 1'b0;
      end else if (align_en && !locked_q && !fail_q) begin
         if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
         end else if (aligned_q == expect_w) begin
            if (match_q == MW'(MATCH_COUNT - 1)) begin
               locked_q <= 1'b1;
               match_q  <= '0;
            end else begin
               match_q <= match_q + 1'b1;
            end
         end else begin
            match_q <= '0;
            if (slip_q == 2'd3) begin
               fail_q <= 1'b1;
            end else begin
               slip_q   <= slip_q + 2'd1;
               settle_q <= SW'(1);
            end
         end
      end
   end

   assign aligned = aligned_q;
   assign locked  = locked_q;
   assign fail    = fail_q;
   assign slip    = slip_q;

   // R5: a shift count at its last position is held until a restart
   p_slip_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slip_q == 2'd3 && !clr) |=> (slip_q == 2'd3));

   // R3: lock is only reached on a cycle that compared equal
   p_lock_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(aligned_q == expect_w));

   // R4: lock and failure exclude each other
   p_lock_fail_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked_q && fail_q));
endmodule

// File: rtl/qra_lat_match.sv
module qra_lat_match #(
   parameter int GROUPS    = 4,
   parameter int WORD_W    = 32,
   parameter int LAT_W     = 5,
   parameter int DLY_DEPTH = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     meas_en,
   input  logic                     latch_eq,
   input  logic [LAT_W-1:0]         cnt,
   input  logic [WORD_W-1:0]        expect_w,
   input  logic [GROUPS*WORD_W-1:0] aligned_bus,
   output logic                     all_seen,
   output logic [LAT_W-1:0]         common_lat,
   output logic                     skew_err,
   output logic [GROUPS*WORD_W-1:0] dout_bus
);
   localparam int DW = (DLY_DEPTH > 0) ? $clog2(DLY_DEPTH + 1) : 1;

   logic [GROUPS-1:0] seen_q;
   logic [LAT_W-1:0]  meas_q [GROUPS];
   logic [DW-1:0]     dsel_q [GROUPS];
   logic [LAT_W-1:0]  max_c;
   logic [LAT_W-1:0]  common_q;
   logic              skew_q;
   logic              eq_done_q;
   logic [GROUPS-1:0] over_c;

   always_comb begin
      max_c = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (meas_q[g] > max_c) max_c = meas_q[g];
      end
   end

   always_comb begin
      for (int g = 0; g < GROUPS; g++) begin
         over_c[g] = (max_c - meas_q[g]) > LAT_W'(DLY_DEPTH);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         common_q  <= '0;
         skew_q    <= 1'b0;
         eq_done_q <= 1'b0;
      end else if (clr) begin
         common_q  <= '0;
         skew_q    <= 1'b0;
         eq_done_q <= 1'b0;
      end else if (latch_eq) begin
         common_q  <= max_c;
         skew_q    <= |over_c;
         eq_done_q <= 1'b1;
      end
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [WORD_W-1:0] a_w;
      logic [WORD_W-1:0] d_w;
      assign a_w = aligned_bus[g*WORD_W +: WORD_W];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seen_q[g] <= 1'b0;
            meas_q[g] <= '0;
            dsel_q[g] <= '0;
         end else if (clr) begin
            seen_q[g] <= 1'b0;
            meas_q[g] <= '0;
            dsel_q[g] <= '0;
         end else begin
            if (meas_en && !seen_q[g] && a_w == expect_w) begin
               seen_q[g] <= 1'b1;
               meas_q[g] <= cnt;
            end
            if (latch_eq) begin
               dsel_q[g] <= over_c[g] ? '0 : DW'(max_c - meas_q[g]);
            end
         end
      end

      if (DLY_DEPTH == 0) begin : g_nodly
         assign d_w = a_w;
      end else begin : g_dly
         logic [WORD_W-1:0] dl_q [1:DLY_DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 1; k <= DLY_DEPTH; k++) dl_q[k] <= '0;
            end else begin
               dl_q[1] <= a_w;
               for (int k = 2; k <= DLY_DEPTH; k++) dl_q[k] <= dl_q[k-1];
            end
         end
         always_comb begin
            d_w = a_w;
            for (int k = 1; k <= DLY_DEPTH; k++) begin
               if (dsel_q[g] == DW'(k)) d_w = dl_q[k];
            end
         end
      end

      assign dout_bus[g*WORD_W +: WORD_W] = d_w;

      // R7: each group's added delay plus its own latency gives the common one
      p_tap_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (eq_done_q && !skew_q) |-> (LAT_W'(dsel_q[g]) + meas_q[g] == common_q));
   end

   assign all_seen   = &seen_q;
   assign common_lat = common_q;
   assign skew_err   = skew_q;
endmodule

// File: rtl/qra_valid_pipe.sv
module qra_valid_pipe #(
   parameter int MAX_LAT = 16,
   parameter int LAT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LAT_W-1:0] lat,
   input  logic             issue,
   output logic             valid
);
   logic [MAX_LAT-1:0] sr_q;
   logic               tap_c;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) sr_q <= '0;
      else               sr_q <= {sr_q[MAX_LAT-2:0], issue};
   end

   always_comb begin
      tap_c = 1'b0;
      for (int k = 1; k <= MAX_LAT; k++) begin
         if (lat == LAT_W'(k)) tap_c = sr_q[k-1];
      end
   end

   assign valid = en && tap_c;

   // R9: a strobe leaves the pipeline only while it is enabled
   p_valid_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> en);
endmodule

// File: rtl/qr_read_align.sv
module qr_read_align #(
   parameter int GROUPS      = 4,
   parameter int BEAT_W      = 8,
   parameter int MATCH_COUNT = 3,
   parameter int MAX_LAT     = 16,
   parameter int DLY_DEPTH   = 4
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      cal_start,
   input  logic [qra_pkg::BEATS*BEAT_W-1:0]          pattern,
   input  logic [GROUPS*qra_pkg::BEATS*BEAT_W-1:0]   raw_data,
   input  logic                                      rd_issue,
   output logic                                      cal_rd_en,
   output logic [GROUPS-1:0]                         grp_locked,
   output logic [GROUPS-1:0]                         grp_fail,
   output logic [2*GROUPS-1:0]                       grp_slip,
   output logic [$clog2(MAX_LAT+1)-1:0]              common_lat,
   output logic                                      cal_done,
   output logic                                      cal_err,
   output logic                                      rd_valid,
   output logic [GROUPS*qra_pkg::BEATS*BEAT_W-1:0]   dout
);
   import qra_pkg::*;

   localparam int WORD_W      = BEATS * BEAT_W;
   localparam int BUS_W       = GROUPS * WORD_W;
   localparam int LAT_W       = $clog2(MAX_LAT + 1);
   localparam int SETTLE_INIT = MAX_LAT + 3;
   localparam int DRAIN_CYC   = MAX_LAT + 3;
   localparam int CW          = $clog2(DRAIN_CYC + 1);

   if (GROUPS < 1)               begin : g_chk_groups $error("GROUPS must be at least 1"); end
   if (BEAT_W < 1)               begin : g_chk_beat   $error("BEAT_W must be at least 1"); end
   if (MATCH_COUNT < 1)          begin : g_chk_match  $error("MATCH_COUNT must be at least 1"); end
   if (MAX_LAT < 4)              begin : g_chk_lat    $error("MAX_LAT must be at least 4"); end
   if (DLY_DEPTH >= MAX_LAT)     begin : g_chk_dly    $error("DLY_DEPTH must be below MAX_LAT"); end

   cal_state_t          st_q;
   logic [CW-1:0]       cnt_q;
   logic [LAT_W-1:0]    lcnt_q;
   logic                err_q;
   logic                clr;
   logic                align_en;
   logic [GROUPS-1:0]   lk;
   logic [GROUPS-1:0]   fl;
   logic [BUS_W-1:0]    aligned_bus;
   logic                all_seen;
   logic                skew_err;
   logic [LAT_W-1:0]    common_c;

   assign clr      = cal_start && (st_q == S_IDLE || st_q == S_DONE);
   assign align_en = (st_q == S_ALIGN);

   for (genvar g = 0; g < GROUPS; g++) begin : g_lane
      qra_slip_lane #(
         .BEAT_W      (BEAT_W),
         .MATCH_COUNT (MATCH_COUNT),
         .SETTLE_INIT (SETTLE_INIT)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .align_en (align_en),
         .raw      (raw_data[g*WORD_W +: WORD_W]),
         .expect_w (pattern),
         .aligned  (aligned_bus[g*WORD_W +: WORD_W]),
         .locked   (lk[g]),
         .fail     (fl[g]),
         .slip     (grp_slip[2*g +: 2])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cnt_q  <= '0;
         lcnt_q <= '0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            S_IDLE, S_DONE: begin
               if (cal_start) begin
                  st_q  <= S_ALIGN;
                  err_q <= 1'b0;
               end
            end
            S_ALIGN: begin
               if (&(lk | fl)) begin
                  cnt_q <= '0;
                  if (|fl) begin
                     err_q <= 1'b1;
                     st_q  <= S_DONE;
                  end else begin
                     st_q <= S_DRAIN;
                  end
               end
            end
            S_DRAIN: begin
               if (cnt_q == CW'(DRAIN_CYC - 1)) st_q <= S_PROBE;
               else                             cnt_q <= cnt_q + 1'b1;
            end
            S_PROBE: begin
               lcnt_q <= LAT_W'(1);
               st_q   <= S_MEASURE;
            end
            S_MEASURE: begin
               if (all_seen) begin
                  st_q <= S_EQUAL;
               end else if (lcnt_q == LAT_W'(MAX_LAT)) begin
                  err_q <= 1'b1;
                  st_q  <= S_DONE;
               end else begin
                  lcnt_q <= lcnt_q + 1'b1;
               end
            end
            S_EQUAL: st_q <= S_DONE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   qra_lat_match #(
      .GROUPS    (GROUPS),
      .WORD_W    (WORD_W),
      .LAT_W     (LAT_W),
      .DLY_DEPTH (DLY_DEPTH)
   ) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .meas_en     (st_q == S_MEASURE),
      .latch_eq    (st_q == S_EQUAL),
      .cnt         (lcnt_q),
      .expect_w    (pattern),
      .aligned_bus (aligned_bus),
      .all_seen    (all_seen),
      .common_lat  (common_c),
      .skew_err    (skew_err),
      .dout_bus    (dout)
   );

   qra_valid_pipe #(
      .MAX_LAT (MAX_LAT),
      .LAT_W   (LAT_W)
   ) u_valid (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cal_done && !cal_err),
      .lat   (common_c),
      .issue (rd_issue),
      .valid (rd_valid)
   );

   assign cal_rd_en  = (st_q == S_ALIGN) || (st_q == S_PROBE);
   assign grp_locked = lk;
   assign grp_fail   = fl;
   assign common_lat = common_c;
   assign cal_done   = (st_q == S_DONE);
   assign cal_err    = err_q || skew_err;

   // R6: the probe read lasts a single cycle
   p_probe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_PROBE) |=> !cal_rd_en);

   // R11: a finished calibration holds until restarted
   p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !cal_start) |=> cal_done);

   // R9: no valid strobe unless calibration ended cleanly
   p_valid_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (cal_done && !cal_err));

   // R4: a failed group always ends in an error
   p_fail_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && |grp_fail) |-> cal_err);
endmodule

// File: tb/qr_read_align_bench.sv
module qr_read_align_bench;
   localparam int G      = 4;
   localparam int BW     = 8;
   localparam int WW     = 4 * BW;
   localparam int MLAT   = 16;
   localparam int DLY    = 4;
   localparam int LW     = $clog2(MLAT + 1);
   localparam int HN     = 8192;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cal_start = 1'b0;
   logic [WW-1:0]   pattern = '0;
   logic [G*WW-1:0] raw_data = '0;
   logic            rd_issue = 1'b0;
   logic            cal_rd_en;
   logic [G-1:0]    grp_locked, grp_fail;
   logic [2*G-1:0]  grp_slip;
   logic [LW-1:0]   common_lat;
   logic            cal_done, cal_err, rd_valid;
   logic [G*WW-1:0] dout;

   int  checks = 0;
   int  errors = 0;
   int  cyc    = 0;
   bit  hist [HN];
   int  rot_m [G];
   int  lat_m [G];
   bit  bad_m [G];

   qr_read_align #(.GROUPS(G), .BEAT_W(BW), .MATCH_COUNT(3), .MAX_LAT(MLAT), .DLY_DEPTH(DLY))
   u_qr_read_align (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .pattern(pattern),
      .raw_data(raw_data), .rd_issue(rd_issue), .cal_rd_en(cal_rd_en),
      .grp_locked(grp_locked), .grp_fail(grp_fail), .grp_slip(grp_slip),
      .common_lat(common_lat), .cal_done(cal_done), .cal_err(cal_err),
      .rd_valid(rd_valid), .dout(dout)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // beat stream model: a read in cycle c puts beat j at stream index 4*(c+L)+j, seen r beats late
   function automatic logic [WW-1:0] build_raw(input int g, input int t);
      logic [WW-1:0] w;
      w = '0;
      for (int j = 0; j < 4; j++) begin
         int n, cy, jj, rc;
         logic [BW-1:0] v;
         n  = 4 * t + j - rot_m[g];
         cy = n / 4;
         jj = n % 4;
         rc = cy - lat_m[g];
         v  = '0;
         if (rc >= 0 && hist[rc % HN]) begin
            v = pattern[jj*BW +: BW];
            if (bad_m[g] && jj == 1) v = v ^ 8'h3C;
         end
         w[j*BW +: BW] = v;
      end
      return w;
   endfunction

   function automatic int exp_common();
      int m = 0;
      for (int g = 0; g < G; g++) if (lat_m[g] > m) m = lat_m[g];
      return m + 2;
   endfunction

   always @(posedge clk) begin
      #1;
      cyc = cyc + 1;
      for (int g = 0; g < G; g++) raw_data[g*WW +: WW] = build_raw(g, cyc);
   end

   always @(negedge clk) begin
      hist[cyc % HN] = cal_rd_en | rd_issue;
      hist[(cyc + 200) % HN] = 1'b0;
   end

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog R2: actual hung expected finished run");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic run_cal(input bit expect_err, input bit expect_fail);
      bit prev_fix = 0;
      int probes = 0;
      int low_en = 0;
      int waited = 0;
      @(posedge clk); #2;
      cal_start = 1'b1;
      @(posedge clk); #2;
      cal_start = 1'b0;
      @(negedge clk);
      chk(cal_done == 1'b0, "R11 done drops", int'(cal_done), 0);
      chk(grp_locked == '0, "R11 locks cleared", int'(grp_locked), 0);
      while (!cal_done && waited < 600) begin
         bit fix;
         fix = &(grp_locked | grp_fail);
         if (!fix && !cal_rd_en) low_en++;
         if (prev_fix && cal_rd_en) probes++;
         prev_fix = fix;
         waited++;
         @(negedge clk);
      end
      chk(cal_done == 1'b1, "R4 done reached", int'(cal_done), 1);
      chk(low_en == 0, "R2 continuous reads", low_en, 0);
      chk(probes == (expect_fail ? 0 : 1), "R6 probe count", probes, expect_fail ? 0 : 1);
      chk(cal_err == expect_err, "R4/R10 error flag", int'(cal_err), int'(expect_err));
   endtask

   task automatic check_groups();
      for (int g = 0; g < G; g++) begin
         chk(grp_locked[g] == 1'b1, "R3 group locked", int'(grp_locked[g]), 1);
         chk(int'(grp_slip[2*g +: 2]) == rot_m[g], "R3 slip count", int'(grp_slip[2*g +: 2]), rot_m[g]);
      end
   endtask

   task automatic traffic(input int n, input bit good);
      int cl = exp_common();
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         rd_issue = ($urandom % 3) == 0;
         @(negedge clk);
         begin
            bit ev;
            ev = good ? hist[(cyc - cl) % HN] : 1'b0;
            chk(rd_valid == ev, "R9 valid timing", int'(rd_valid), int'(ev));
            if (good) begin
               for (int g = 0; g < G; g++) begin
                  bit hit = (dout[g*WW +: WW] == pattern);
                  chk(hit == ev, "R8 aligned word", int'(hit), int'(ev));
               end
            end
         end
      end
      @(posedge clk); #2;
      rd_issue = 1'b0;
      repeat (MLAT + 2) @(posedge clk);
   endtask

   task automatic good_round();
      run_cal(1'b0, 1'b0);
      check_groups();
      chk(int'(common_lat) == exp_common(), "R7 common latency", int'(common_lat), exp_common());
      chk(grp_fail == '0, "R4 no fail", int'(grp_fail), 0);
      traffic(120, 1'b1);
   endtask

   initial begin
      void'($urandom(32'h51A7));
      for (int j = 0; j < 4; j++) pattern[j*BW +: BW] = 8'(8'h11 * (j + 1) + ($urandom % 8) * 8'h40);
      for (int g = 0; g < G; g++) begin rot_m[g] = 0; lat_m[g] = 3; bad_m[g] = 0; end
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(cal_done == 0 && cal_err == 0, "R1 reset flags", int'({cal_done, cal_err}), 0);
      chk(cal_rd_en == 0 && rd_valid == 0, "R1 reset strobes", int'({cal_rd_en, rd_valid}), 0);
      chk(grp_locked == 0 && grp_fail == 0, "R1 reset groups", int'({grp_locked, grp_fail}), 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cal_done == 0 && cal_rd_en == 0 && rd_valid == 0, "R1 after release", int'({cal_done, cal_rd_en, rd_valid}), 0);

      // directed: no rotation, equal latency
      good_round();
      // directed: every rotation, skew exactly DLY
      rot_m = '{3, 2, 1, 0};
      lat_m = '{2, 6, 4, 3};
      good_round();
      // random rounds
      for (int r = 0; r < 4; r++) begin
         for (int g = 0; g < G; g++) begin
            rot_m[g] = $urandom % 4;
            lat_m[g] = 2 + $urandom % (DLY + 1);
         end
         good_round();
      end
      // R4, R5: group 2 never matches
      rot_m = '{1, 0, 2, 3};
      lat_m = '{3, 3, 4, 2};
      bad_m[2] = 1'b1;
      run_cal(1'b1, 1'b1);
      chk(grp_fail == 4'b0100, "R4 fail flag", int'(grp_fail), 4);
      chk(int'(grp_slip[5:4]) == 3, "R5 slip saturates", int'(grp_slip[5:4]), 3);
      traffic(40, 1'b0);
      bad_m[2] = 1'b0;
      // R10: skew beyond the delay line
      rot_m = '{0, 1, 2, 3};
      lat_m = '{2, 8, 3, 3};
      run_cal(1'b1, 1'b0);
      chk(grp_fail == '0, "R10 no group fail", int'(grp_fail), 0);
      traffic(40, 1'b0);
      // R11: recovery with a fresh calibration
      rot_m = '{2, 3, 0, 1};
      lat_m = '{5, 2, 6, 4};
      good_round();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule